// File: doc/BRIEF.md
# Cycle-Count Event Timing Wheel

This block schedules event identifiers to reappear after a programmed number of clock cycles. A requester presents an identifier together with a delay. The wheel files the identifier under the slot given by the running cycle count plus the delay, taken modulo the number of slots. A free-running cycle counter moves the wheel position forward by one slot on every clock. Each slot that the position reaches is captured into an output buffer, and its identifiers are then presented on a valid/ready stream. Whatever acts on those identifiers sits downstream and is not part of this block.

Each slot is a small fixed-capacity stack. If a request targets a slot that is already full, the block raises a same-cycle flag and discards that request. When the output stream is held off, the wheel keeps turning and counts the slots it has passed. Once the stream frees up, the block catches up on those slots in wheel order, wrapping from the last slot back to slot 0. Empty slots are skipped and cost no output cycles.

Top module: `event_wheel`

## Requirements
- R1: After reset `ev_valid` and `sched_full` are low, `cycle_now` is 0 in the first cycle after reset, and every slot is empty.
- R2: `cycle_now` counts every clock since reset. A request with delay d (1 to SLOTS-1) accepted in cycle c, with no backlog, targets slot (`cycle_now` + d) mod SLOTS, and its identifier is on `ev_id` with `ev_valid` high in cycle c+d+1.
- R3: A request with delay 0 is ignored. It stores nothing, does not raise `sched_full`, and never produces an output.
- R4: Delays of SLOTS or more are reduced modulo SLOTS. A nonzero multiple of SLOTS accepted in cycle c, with no backlog, is output in cycle c+SLOTS+1.
- R5: Identifiers filed in the same slot are output newest first.
- R6: A slot holds at most DEPTH identifiers. A request into a full slot raises `sched_full` in the same cycle, combinationally, and is discarded. The identifiers already in that slot are unaffected.
- R7: A request whose target slot is being captured for output in that same cycle is not merged into that capture. It becomes the sole content of the slot and is output on the next visit to the slot.
- R8: While `ev_valid` is high and `ev_ready` is low, `ev_valid` stays high and `ev_id` is unchanged in the next cycle.
- R9: Slots passed while the output was stalled are drained afterwards in increasing slot order, starting after the last captured slot and wrapping from SLOTS-1 to 0. All identifiers of one slot are output back to back, and empty slots take no output cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sched_valid | input | 1 | Schedule request present this cycle |
| sched_delay | input | DLY_W | Delay in cycles for the request |
| sched_id | input | ID_W | Identifier to schedule |
| sched_full | output | 1 | Request discarded because its target slot is full |
| cycle_now | output | CNT_W | Free-running cycle count since reset |
| ev_valid | output | 1 | An identifier is presented on the output stream |
| ev_id | output | ID_W | Presented identifier |
| ev_ready | input | 1 | Downstream accepts the presented identifier |

## Verification
The hardest case to reach from the ports is a capture that meets a new request for the same slot in the same cycle. It also has to happen while a backlog spans the wrap from the last slot to slot 0. The bench reaches the collision directly by issuing a delay of exactly SLOTS in the cycle the current slot, already holding an event, is captured. It reaches the wrapped backlog by holding `ev_ready` low for many wheel turns while requests keep arriving. A behavioural queue model is compared against the outputs on every clock during directed phases and a long random phase with bursty stalls.

// File: rtl/event_wheel.sv
`timescale 1ns / 1ps
module event_wheel #(
  parameter int SLOTS = 8,
  parameter int DEPTH = 4,
  parameter int ID_W  = 8,
  parameter int DLY_W = 8,
  parameter int CNT_W = 32,
  parameter int DUE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sched_valid,
  input  logic [DLY_W-1:0] sched_delay,
  input  logic [ID_W-1:0]  sched_id,
  output logic             sched_full,
  output logic [CNT_W-1:0] cycle_now,
  output logic             ev_valid,
  output logic [ID_W-1:0]  ev_id,
  input  logic             ev_ready
);
  localparam int SW = $clog2(SLOTS);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] now_q;
  logic [SW-1:0]    srv_q;
  logic [DUE_W-1:0] due_q;
  logic [CW-1:0]    cnt_q  [SLOTS];
  logic [ID_W-1:0]  ids_q  [SLOTS][DEPTH];
  logic [CW-1:0]    bcnt_q;
  logic [ID_W-1:0]  bids_q [DEPTH];

  logic [SW-1:0] pos, tgt, hk, load_slot;
  logic [IW-1:0] wr_ix;
  logic [CW-1:0] left;
  logic [DUE_W:0] due_eff;
  logic fire, can_load, hit, load, req, clash, put;

  assign cycle_now = now_q;
  assign pos       = now_q[SW-1:0];
  assign ev_valid  = bcnt_q != '0;
  assign ev_id     = bids_q[IW'(bcnt_q - 1'b1)];
  assign fire      = ev_valid & ev_ready;
  assign left      = bcnt_q - CW'(fire);
  assign can_load  = left == '0;
  assign due_eff   = {1'b0, due_q} + 1'b1;

  always_comb begin
    hit = 1'b0;
    hk  = '0;
    for (int k = SLOTS - 1; k >= 0; k--) begin
      if ((DUE_W + 1)'(k) < due_eff && cnt_q[srv_q + SW'(k)] != '0) begin
        hit = 1'b1;
        hk  = SW'(k);
      end
    end
  end

  assign load_slot  = srv_q + hk;
  assign load       = can_load & hit;
  assign tgt        = pos + sched_delay[SW-1:0];
  assign req        = sched_valid && sched_delay != '0;
  assign clash      = load && load_slot == tgt;
  assign sched_full = req && !clash && cnt_q[tgt] == CW'(DEPTH);
  assign put        = req && !sched_full;
  assign wr_ix      = clash ? '0 : IW'(cnt_q[tgt]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q  <= '0;
      srv_q  <= '0;
      due_q  <= '0;
      bcnt_q <= '0;
      for (int d = 0; d < DEPTH; d++) bids_q[d] <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        cnt_q[i] <= '0;
        for (int d = 0; d < DEPTH; d++) ids_q[i][d] <= '0;
      end
    end else begin
      now_q <= now_q + 1'b1;
      if (can_load) begin
        if (hit) begin
          bcnt_q <= cnt_q[load_slot];
          bids_q <= ids_q[load_slot];
          srv_q  <= load_slot + 1'b1;
          due_q  <= DUE_W'(due_eff - (DUE_W + 1)'(hk) - 1'b1);
        end else begin
          bcnt_q <= '0;
          srv_q  <= srv_q + due_eff[SW-1:0];
          due_q  <= '0;
        end
      end else begin
        bcnt_q <= left;
        due_q  <= (&due_q) ? due_q : due_q + 1'b1;
      end
      for (int i = 0; i < SLOTS; i++) begin
        if (load && load_slot == SW'(i)) cnt_q[i] <= '0;
        if (put && tgt == SW'(i)) begin
          ids_q[i][wr_ix] <= sched_id;
          cnt_q[i]        <= clash ? CW'(1) : cnt_q[i] + 1'b1;
        end
      end
    end
  end

  assert_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bcnt_q == '0 && due_q == '0) |=> (srv_q == SW'($past(pos) + 1'b1) && due_q == '0));

  assert_zero_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sched_valid && sched_delay == '0 && !(load && load_slot == tgt))
      |=> cnt_q[$past(tgt)] == $past(cnt_q[tgt]));

  assert_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (put && !clash) |=> cnt_q[$past(tgt)] == CW'($past(cnt_q[tgt]) + 1'b1));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sched_full |=> cnt_q[$past(tgt)] == CW'(DEPTH));

  assert_clash_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (put && clash) |=> cnt_q[$past(tgt)] == CW'(1));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_id)));
endmodule

// File: tb/sim_event_wheel.sv
`timescale 1ns / 1ps
module sim_event_wheel;
  localparam int S = 8;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sched_valid = 1'b0;
  logic [7:0] sched_delay = '0;
  logic [7:0] sched_id = '0;
  logic sched_full;
  logic [31:0] cycle_now;
  logic ev_valid;
  logic [7:0] ev_id;
  logic ev_ready = 1'b1;

  always #5 clk = ~clk;

  event_wheel u0 (
    .clk(clk), .rst_n(rst_n), .sched_valid(sched_valid), .sched_delay(sched_delay),
    .sched_id(sched_id), .sched_full(sched_full), .cycle_now(cycle_now),
    .ev_valid(ev_valid), .ev_id(ev_id), .ev_ready(ev_ready)
  );

  int checks = 0;
  int errors = 0;
  int mq [S][$];
  int mbuf [$];
  int got [$];
  int mnow = 0, msrv = 0, mdue = 0;
  bit last_valid, last_full;
  int last_id;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    bit ev, ef, req;
    int eid, found, ld, t;
    #2;
    ev  = mbuf.size() != 0;
    eid = ev ? mbuf[$] : 0;
    if (ev && ev_ready) void'(mbuf.pop_back());
    found = -1;
    if (mbuf.size() == 0)
      for (int k = 0; k < S && k < mdue + 1; k++)
        if (mq[(msrv + k) % S].size() != 0) begin found = k; break; end
    ld  = (found >= 0) ? (msrv + found) % S : -1;
    req = sched_valid && sched_delay != 0;
    t   = (mnow + int'(sched_delay)) % S;
    ef  = req && t != ld && mq[t].size() == DEPTH;
    check(ev_valid == ev, "R8 valid", ev_valid, ev);
    if (ev) check(ev_id == eid[7:0], "R5 id", ev_id, eid);
    check(sched_full == ef, "R6 full", sched_full, ef);
    check(cycle_now == 32'(mnow), "R2 count", cycle_now, mnow);
    last_valid = ev_valid; last_id = ev_id; last_full = sched_full;
    if (ev_valid && ev_ready) got.push_back(int'(ev_id));
    if (mbuf.size() == 0) begin
      if (found >= 0) begin
        mbuf = mq[ld];
        mq[ld].delete();
        msrv = (ld + 1) % S;
        mdue = mdue - found;
      end else begin
        msrv = (msrv + mdue + 1) % S;
        mdue = 0;
      end
    end else mdue = mdue + 1;
    if (req && !ef) mq[t].push_back(int'(sched_id));
    mnow++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    sched_valid = 1'b0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic put(input int id, input int dly);
    sched_valid = 1'b1; sched_id = id[7:0]; sched_delay = dly[7:0];
    step();
    sched_valid = 1'b0;
  endtask

  task automatic latency(input int id, input int dly, input int exp, input string tag);
    int k;
    put(id, dly);
    k = 0;
    do begin step(); k++; end while (!last_valid && k < 40);
    check(k == exp && last_id == id, tag, k, exp);
  endtask

  initial begin
    #200us;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", mnow, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(ev_valid == 1'b0, "R1 valid", ev_valid, 0);
    check(sched_full == 1'b0, "R1 full", sched_full, 0);
    check(cycle_now == 0, "R1 count", cycle_now, 0);
    idle(2 * S);
    check(got.size() == 0, "R1 empty", got.size(), 0);

    latency(8'h11, 3, 4, "R2 latency");
    idle(S);
    latency(8'h12, S + 2, 3, "R4 alias");
    idle(S);

    got.delete();
    put(8'h21, 6); put(8'h22, 5); put(8'h23, 4);
    idle(10);
    check(got.size() == 3 && got[0] == 8'h23 && got[1] == 8'h22 && got[2] == 8'h21,
          "R5 order", got.size() > 0 ? got[0] : -1, 8'h23);

    got.delete();
    put(8'h41, 7); check(!last_full, "R6 accept", last_full, 0);
    put(8'h42, 6); put(8'h43, 5); put(8'h44, 4);
    check(!last_full, "R6 accept4", last_full, 0);
    put(8'h45, 3);
    check(last_full, "R6 overflow", last_full, 1);
    idle(12);
    check(got.size() == 4 && got[0] == 8'h44 && got[3] == 8'h41,
          "R6 kept", got.size(), 4);

    got.delete();
    put(8'h55, 0);
    check(!last_full, "R3 nofull", last_full, 0);
    idle(S + 4);
    check(got.size() == 0, "R3 ignored", got.size(), 0);

    got.delete();
    put(8'h71, 4);
    idle(3);
    put(8'h72, S);
    idle(6);
    check(got.size() == 1 && got[0] == 8'h71, "R7 separate", got.size(), 1);
    idle(6);
    check(got.size() == 2 && got[1] == 8'h72, "R7 next_visit", got.size(), 2);
    check(got.size() == 2, "R4 multiple", got.size(), 2);

    got.delete();
    ev_ready = 1'b0;
    put(8'h81, 2); put(8'h82, 5); put(8'h83, 7);
    idle(4);
    check(last_valid && last_id == 8'h81, "R8 hold", last_id, 8'h81);
    idle(15);
    check(last_valid && last_id == 8'h81, "R8 stable", last_id, 8'h81);
    ev_ready = 1'b1;
    idle(12);
    check(got.size() == 3 && got[0] == 8'h81 && got[1] == 8'h82 && got[2] == 8'h83,
          "R9 backlog", got.size(), 3);

    for (int c = 0; c < 3000; c++) begin
      sched_valid = ($urandom_range(0, 2) == 0);
      sched_delay = 8'($urandom_range(0, 20));
      sched_id    = 8'($urandom);
      ev_ready    = ((c % 500) < 470) ? ($urandom_range(0, 2) != 0) : 1'b0;
      step();
    end
    sched_valid = 1'b0;
    ev_ready = 1'b1;
    idle(40);
    check(mbuf.size() == 0 && !last_valid, "R9 drained", last_valid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule